// File: doc/BRIEF.md
# Debug Trigger Control Register Bank

This block keeps the control and status register state for a small group of hardware debug triggers in a 32-bit processor. Software picks one trigger through a select register. It then reads and writes that trigger's control word, compare word and auxiliary word through a single CSR port. A read-only capability word reports which trigger kinds the bank accepts. The control and compare words of every trigger go out in parallel, as registered vectors, to the address-match logic that sits beside the bank.

The kind of a control write is taken from the top nibble of the data being written. Two kinds are accepted: an address/data match trigger (kind 2) and an extended address/data match trigger (kind 6). Each kind is cleaned before it is stored. Fields the bank does not implement are cleared, and an unsupported access-size code is replaced by the "any size" code. A write that names any other kind is dropped and leaves all state as it was. Compare-word writes take their kind from the control word already stored for the selected trigger. Auxiliary-word writes are always dropped.

Top module: `trig_csr_bank`

## Requirements
- R1: After reset, the select register is 0. Every trigger's control word is 0x2000_0000 (kind 2, every other bit 0). Every compare word is 0.
- R2: A write to the select register (address 0) takes effect only when the written value, read as an unsigned 32-bit number, is below NUM_TRIG. Any other value leaves the select register unchanged.
- R3: When csr_rd is high, csr_rdata shows the result on the next clock edge. Address 0 returns the select value. Address 1 returns the selected control word. Address 2 returns the selected compare word. Address 3 returns 0. Addresses 5 to 7 return 0.
- R4: A read of address 4 returns 0x0000_0044, which has only bits 2 and 6 set.
- R5: A control write (address 1) takes its kind from bits [31:28] of the written data. Any kind other than 2 or 6 leaves all control and compare words unchanged.
- R6: A kind-2 control write stores 0x2 in bits [31:28] and keeps written bits 17, 16, 6, 4, 3, 2, 1 and 0. Every other bit is stored as 0, including bit 27.
- R7: A kind-6 control write stores 0x6 in bits [31:28] and keeps written bits 24, 23, 6, 4, 3, 2, 1 and 0. The size field in bits [19:16] is kept when its code is 0, 1, 2, 3 or 5, and is stored as 0 otherwise. Every other bit is stored as 0.
- R8: A compare write (address 2) stores the full 32-bit word into the selected trigger, because the stored kind of that trigger is always 2 or 6.
- R9: A write to the auxiliary word (address 3) changes no state, and that word always reads as 0.
- R10: trig_ctrl and trig_cmp carry trigger i in bits [32i+31:32i]. They show a write from the clock edge that accepts it, and only the selected trigger changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| csr_wr | input | 1 | Write strobe |
| csr_rd | input | 1 | Read strobe |
| csr_addr | input | 3 | Register address (0 select, 1 control, 2 compare, 3 auxiliary, 4 capability) |
| csr_wdata | input | 32 | Write data |
| csr_rdata | output | 32 | Registered read data |
| trig_ctrl | output | 32*NUM_TRIG | Control words of all triggers |
| trig_cmp | output | 32*NUM_TRIG | Compare words of all triggers |

## Verification
The assertions assume that csr_wr and csr_rd change only between clock edges. They also assume that the address and data are stable whenever a strobe is high. The bench drives every input on the falling edge and holds each strobe for one whole cycle, so this always holds. The bench also assumes that stored kinds are only ever 2 or 6. It keeps to that by reaching state only through the CSR port, including the write patterns that try to store other kinds.

// File: rtl/trig_csr_pkg.sv
package trig_csr_pkg;
  localparam int XLEN = 32;

  typedef enum logic [2:0] {
    A_SEL  = 3'd0,
    A_CTRL = 3'd1,
    A_CMP  = 3'd2,
    A_AUX  = 3'd3,
    A_CAP  = 3'd4
  } csr_addr_e;

  localparam logic [3:0] KIND_MATCH  = 4'd2;
  localparam logic [3:0] KIND_MATCHX = 4'd6;

  localparam logic [XLEN-1:0] CAP_WORD   = (32'd1 << KIND_MATCH) | (32'd1 << KIND_MATCHX);
  localparam logic [XLEN-1:0] KEEP_MATCH = 32'h0003_005F;
  localparam logic [XLEN-1:0] KEEP_MATCHX = 32'h0180_005F;
  localparam logic [XLEN-1:0] RESET_CTRL = {KIND_MATCH, 28'd0};

  function automatic logic size_code_ok(input logic [3:0] code);
    return (code <= 4'd3) || (code == 4'd5);
  endfunction
endpackage

// File: rtl/trig_ctrl_sanitize.sv
module trig_ctrl_sanitize
  import trig_csr_pkg::*;
(
  input  logic [XLEN-1:0] raw,
  output logic            legal,
  output logic [XLEN-1:0] clean
);
  logic [3:0] kind;
  logic [3:0] size_code;

  assign kind      = raw[31:28];
  assign size_code = raw[19:16];

  always_comb begin
    legal = 1'b0;
    clean = '0;
    case (kind)
      KIND_MATCH: begin
        legal = 1'b1;
        clean = {KIND_MATCH, 28'd0} | (raw & KEEP_MATCH);
      end
      KIND_MATCHX: begin
        legal = 1'b1;
        clean = {KIND_MATCHX, 28'd0} | (raw & KEEP_MATCHX);
        if (size_code_ok(size_code)) begin
          clean[19:16] = size_code;
        end
      end
      default: begin
        legal = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/trig_slot.sv
module trig_slot
  import trig_csr_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            ctrl_we,
  input  logic            cmp_we,
  input  logic [XLEN-1:0] ctrl_d,
  input  logic [XLEN-1:0] cmp_d,
  output logic [XLEN-1:0] ctrl_q,
  output logic [XLEN-1:0] cmp_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= RESET_CTRL;
      cmp_q  <= '0;
    end else begin
      if (ctrl_we) ctrl_q <= ctrl_d;
      if (cmp_we)  cmp_q  <= cmp_d;
    end
  end
endmodule

// File: rtl/trig_csr_bank.sv
module trig_csr_bank
  import trig_csr_pkg::*;
#(
  parameter int NUM_TRIG = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     csr_wr,
  input  logic                     csr_rd,
  input  logic [2:0]               csr_addr,
  input  logic [XLEN-1:0]          csr_wdata,
  output logic [XLEN-1:0]          csr_rdata,
  output logic [NUM_TRIG*XLEN-1:0] trig_ctrl,
  output logic [NUM_TRIG*XLEN-1:0] trig_cmp
);
  localparam int SEL_W = (NUM_TRIG > 1) ? $clog2(NUM_TRIG) : 1;

  logic [SEL_W-1:0] sel_q;
  logic [XLEN-1:0]  ctrl_w [NUM_TRIG];
  logic [XLEN-1:0]  cmp_w  [NUM_TRIG];
  logic             ctrl_legal;
  logic [XLEN-1:0]  ctrl_clean;
  logic             wr_sel, wr_ctrl, wr_cmp;
  logic [3:0]       cur_kind;
  logic             cur_kind_ok;

  assign wr_sel  = csr_wr && (csr_addr == A_SEL);
  assign wr_ctrl = csr_wr && (csr_addr == A_CTRL) && ctrl_legal;
  assign cur_kind    = ctrl_w[sel_q][31:28];
  assign cur_kind_ok = (cur_kind == KIND_MATCH) || (cur_kind == KIND_MATCHX);
  assign wr_cmp  = csr_wr && (csr_addr == A_CMP) && cur_kind_ok;

  trig_ctrl_sanitize i_sanitize (
    .raw   (csr_wdata),
    .legal (ctrl_legal),
    .clean (ctrl_clean)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q <= '0;
    end else if (wr_sel && (csr_wdata < XLEN'(NUM_TRIG))) begin
      sel_q <= csr_wdata[SEL_W-1:0];
    end
  end

  for (genvar g = 0; g < NUM_TRIG; g++) begin : g_slot
    logic hit;
    assign hit = (sel_q == SEL_W'(g));

    trig_slot i_slot (
      .clk     (clk),
      .rst     (rst),
      .ctrl_we (wr_ctrl && hit),
      .cmp_we  (wr_cmp && hit),
      .ctrl_d  (ctrl_clean),
      .cmp_d   (csr_wdata),
      .ctrl_q  (ctrl_w[g]),
      .cmp_q   (cmp_w[g])
    );

    assign trig_ctrl[g*XLEN +: XLEN] = ctrl_w[g];
    assign trig_cmp[g*XLEN +: XLEN]  = cmp_w[g];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      csr_rdata <= '0;
    end else if (csr_rd) begin
      case (csr_addr)
        A_SEL:   csr_rdata <= XLEN'(sel_q);
        A_CTRL:  csr_rdata <= ctrl_w[sel_q];
        A_CMP:   csr_rdata <= cmp_w[sel_q];
        A_AUX:   csr_rdata <= '0;
        A_CAP:   csr_rdata <= CAP_WORD;
        default: csr_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/trig_csr_bank_chk.sv
module trig_csr_bank_chk
  import trig_csr_pkg::*;
#(
  parameter int NUM_TRIG = 4,
  parameter int SEL_W    = 2
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     csr_wr,
  input logic                     csr_rd,
  input logic [2:0]               csr_addr,
  input logic [XLEN-1:0]          csr_wdata,
  input logic [XLEN-1:0]          csr_rdata,
  input logic [NUM_TRIG*XLEN-1:0] trig_ctrl,
  input logic [NUM_TRIG*XLEN-1:0] trig_cmp,
  input logic [SEL_W-1:0]         sel_q
);
  // R2
  sel_range_chk: assert property (@(posedge clk) disable iff (rst)
    (32'(sel_q) < NUM_TRIG));

  // R2
  sel_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (csr_wr && csr_addr == A_SEL && csr_wdata >= XLEN'(NUM_TRIG)) |=> $stable(sel_q));

  // R4
  cap_read_chk: assert property (@(posedge clk) disable iff (rst)
    (csr_rd && csr_addr == A_CAP) |=> (csr_rdata == CAP_WORD));

  // R5
  bad_kind_chk: assert property (@(posedge clk) disable iff (rst)
    (csr_wr && csr_addr == A_CTRL && csr_wdata[31:28] != KIND_MATCH &&
     csr_wdata[31:28] != KIND_MATCHX) |=> ($stable(trig_ctrl) && $stable(trig_cmp)));

  // R9
  aux_write_chk: assert property (@(posedge clk) disable iff (rst)
    (csr_wr && csr_addr == A_AUX) |=> ($stable(trig_ctrl) && $stable(trig_cmp)));

  for (genvar g = 0; g < NUM_TRIG; g++) begin : g_slot_chk
    // R6
    dmode_zero_chk: assert property (@(posedge clk) disable iff (rst)
      !trig_ctrl[g*XLEN + 27]);

    // R7
    size_code_chk: assert property (@(posedge clk) disable iff (rst)
      (trig_ctrl[g*XLEN+28 +: 4] == KIND_MATCHX) |-> size_code_ok(trig_ctrl[g*XLEN+16 +: 4]));
  end
endmodule

bind trig_csr_bank trig_csr_bank_chk #(
  .NUM_TRIG (NUM_TRIG),
  .SEL_W    (SEL_W)
) i_chk (
  .clk       (clk),
  .rst       (rst),
  .csr_wr    (csr_wr),
  .csr_rd    (csr_rd),
  .csr_addr  (csr_addr),
  .csr_wdata (csr_wdata),
  .csr_rdata (csr_rdata),
  .trig_ctrl (trig_ctrl),
  .trig_cmp  (trig_cmp),
  .sel_q     (sel_q)
);

// File: tb/test_trig_csr_bank.sv
module test_trig_csr_bank;
  localparam int N = 4;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            csr_wr = 1'b0;
  logic            csr_rd = 1'b0;
  logic [2:0]      csr_addr = '0;
  logic [31:0]     csr_wdata = '0;
  logic [31:0]     csr_rdata;
  logic [N*32-1:0] trig_ctrl;
  logic [N*32-1:0] trig_cmp;

  int checks = 0;
  int failures = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #4 clk = ~clk;

  trig_csr_bank #(.NUM_TRIG(N)) i_trig_csr_bank (
    .clk(clk), .rst(rst), .csr_wr(csr_wr), .csr_rd(csr_rd),
    .csr_addr(csr_addr), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
    .trig_ctrl(trig_ctrl), .trig_cmp(trig_cmp)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    csr_wr = 1'b1; csr_addr = a; csr_wdata = d;
    @(negedge clk);
    csr_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    csr_rd = 1'b1; csr_addr = a;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk);
    csr_rd = 1'b0;
  endtask

  // monitor: pops expected read data as the design returns it
  initial begin
    forever begin
      logic was_rd;
      @(posedge clk);
      was_rd = csr_rd;
      #1;
      if (was_rd && !rst) begin
        if (exp_q.size() == 0) begin
          check("R3 unexpected read", csr_rdata, 32'hx);
        end else begin
          check(tag_q.pop_front(), csr_rdata, exp_q.pop_front());
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    for (int i = 0; i < N; i++) begin
      check("R1 reset ctrl", trig_ctrl[i*32 +: 32], 32'h2000_0000);
      check("R1 reset cmp", trig_cmp[i*32 +: 32], 32'h0);
    end
    rd(3'd0, 32'd0, "R1 reset select");
    rd(3'd4, 32'h0000_0044, "R4 capability");

    wr(3'd0, 32'd2);
    rd(3'd0, 32'd2, "R2 select in range");
    wr(3'd0, 32'd4);
    rd(3'd0, 32'd2, "R2 select equal to count ignored");
    wr(3'd0, 32'h8000_0001);
    rd(3'd0, 32'd2, "R2 select large ignored");

    wr(3'd1, 32'h2FFF_FFFF);
    check("R6 kind2 clean", trig_ctrl[2*32 +: 32], 32'h2003_005F);
    check("R10 other slot untouched", trig_ctrl[1*32 +: 32], 32'h2000_0000);
    rd(3'd1, 32'h2003_005F, "R3 read ctrl");

    wr(3'd1, 32'h6FFF_FFFF);
    check("R7 kind6 bad size", trig_ctrl[2*32 +: 32], 32'h6180_005F);
    wr(3'd1, 32'h6005_0048);
    check("R7 kind6 size 5 kept", trig_ctrl[2*32 +: 32], 32'h6005_0048);
    wr(3'd1, 32'h6004_0001);
    check("R7 kind6 size 4 dropped", trig_ctrl[2*32 +: 32], 32'h6000_0001);
    wr(3'd1, 32'h6003_0002);
    check("R7 kind6 size 3 kept", trig_ctrl[2*32 +: 32], 32'h6003_0002);

    wr(3'd1, 32'h3000_0044);
    check("R5 kind3 ignored", trig_ctrl[2*32 +: 32], 32'h6003_0002);
    wr(3'd1, 32'h0000_0047);
    check("R5 kind0 ignored", trig_ctrl[2*32 +: 32], 32'h6003_0002);
    wr(3'd1, 32'hF000_0001);
    check("R5 kind15 ignored", trig_ctrl[2*32 +: 32], 32'h6003_0002);

    wr(3'd2, 32'hDEAD_BEEF);
    check("R8 cmp stored", trig_cmp[2*32 +: 32], 32'hDEAD_BEEF);
    check("R10 cmp other slot", trig_cmp[3*32 +: 32], 32'h0);
    rd(3'd2, 32'hDEAD_BEEF, "R3 read cmp");

    wr(3'd3, 32'h0000_1234);
    rd(3'd3, 32'h0, "R9 aux reads zero");
    check("R9 aux ctrl unchanged", trig_ctrl[2*32 +: 32], 32'h6003_0002);
    check("R9 aux cmp unchanged", trig_cmp[2*32 +: 32], 32'hDEAD_BEEF);

    wr(3'd0, 32'd0);
    rd(3'd1, 32'h2000_0000, "R3 read ctrl slot0");
    wr(3'd1, 32'h2800_0004);
    check("R6 dmode cleared", trig_ctrl[0 +: 32], 32'h2000_0004);
    rd(3'd5, 32'h0, "R3 unknown address");

    wait (exp_q.size() == 0);
    repeat (2) @(posedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule